// File: doc/BRIEF.md
# Calibration Tone Tracker and Canceller for a Two-Way Interleaved ADC

This block sits behind a pair of 14-bit sub-converters that sample on opposite clock phases. A small sinusoidal calibration tone is injected in the unused band near the band edge. Its frequency is tied to the converter clock through a programmable integer K. For each sub-converter stream the block builds a cosine reference and a sine reference at that frequency. It adapts one in-phase weight and one quadrature weight per channel with a sign-preserving least-mean-squares update. From these it rebuilds the tone each channel carries.

Each channel produces two outputs: the data with the tracked tone subtracted, and the rebuilt tone on its own. A later mismatch estimator consumes the pair of rebuilt tones. Only one cosine table exists. The quadrature reference is the cosine reference delayed by K samples of the same channel, which is a quarter of the tone period. The adaptation rate is set by a right-shift amount.

Top module: `tone_lms_extractor`

## Requirements
- R1: While `rst_n` is low and until the first valid sample, `out_valid`, both cleaned outputs and both tone outputs are zero. Reset also clears both weights of both channels, the sample index and the quadrature delay lines.
- R2: The table holds 256 entries. Entry a is computed as follows: b = (a+64) mod 256, p = b mod 128, q = p·(128−p), m = ⌊2047·16·q / (81920 − 4q)⌋. The entry is +m when b < 128 and −m otherwise. For sample index n and channel c, the table address is ⌊(2n+c)·⌊65536/K⌋ / 2048⌋ mod 256. This places channel 1 half a channel-sample later than channel 0.
- R3: The sine reference of a channel is that channel's cosine reference from exactly K valid samples earlier. It is zero until K valid samples have passed since reset.
- R4: The shared sample index advances by one on each valid sample and returns to 0 after reaching 4K−1. If K is lowered so that the index is already at or past 4K−1, the index returns to 0 on the next valid sample. A `k_sel` of 0 is treated as K = 1.
- R5: The tone estimate is y = ⌊(wc·cos + ws·sin) / 2^19⌋, and the error is e = x − y, with x taken as a signed sample.
- R6: On each valid sample, wc grows by ⌊e·cos / 2^μ⌋ and ws grows by ⌊e·sin / 2^μ⌋. Here μ is `mu_sel` clamped to the range 8 to 20.
- R7: Weights are 22-bit signed values. An update that would leave the range [−2^21, 2^21−1] holds at the limit it crossed.
- R8: One clock after a valid sample, `out_valid` is 1. The cleaned output is e, and the tone output is y, each saturated to a signed 14-bit value.
- R9: A cycle with `in_valid` low changes no weight and no index. It leaves all four data outputs at their previous values and drives `out_valid` to 0.
- R10: With a pure tone of amplitude near −40 dBFS at the reference frequency and μ = 8, every cleaned output stays within ±4 after 3000 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Both sub-converter samples are present this cycle |
| x0_in | input | 14 | Sub-converter 0 sample, two's complement |
| x1_in | input | 14 | Sub-converter 1 sample, two's complement |
| k_sel | input | 6 | Tone frequency integer K (1 to 63; 0 is read as 1) |
| mu_sel | input | 5 | Adaptation shift, clamped to 8..20 |
| out_valid | output | 1 | Outputs updated by the previous valid sample |
| clean0 | output | 14 | Channel 0 data with tone removed |
| clean1 | output | 14 | Channel 1 data with tone removed |
| tone0 | output | 14 | Rebuilt tone of channel 0 |
| tone1 | output | 14 | Rebuilt tone of channel 1 |

## Verification
The bench builds the block with its default parameters: 14-bit samples, 12-bit references, 22-bit weights and K up to 63. At these values the widest K gives a 252-sample period, and K = 1 gives the shortest, a 4-sample period. K can also be lowered mid-run so that the index wraps early. A full-scale square input pushes the 22-bit weights into saturation within a few hundred samples, and an input near −40 dBFS lets the residual after convergence be bounded at the ports.

// File: rtl/tlx_pkg.sv
package tlx_pkg;

  // Integer cosine approximation for entry a of a table with 2*half entries.
  // Uses a rational half-wave sine shape so no real arithmetic is needed.
  function automatic int cos_entry(input int a, input int half, input int amp);
    int b;
    int p;
    int q;
    int mag;
    b   = (a + half / 2) % (2 * half);
    p   = b % half;
    q   = p * (half - p);
    mag = (amp * 16 * q) / (5 * half * half - 4 * q);
    return (b < half) ? mag : -mag;
  endfunction

endpackage

// File: rtl/tlx_ref_gen.sv
module tlx_ref_gen #(
  parameter int RW   = 12,
  parameter int KMAX = 63,
  parameter int KW   = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic [KW-1:0]         k_sel,
  output logic [1:0][RW-1:0]    cos_o,
  output logic [1:0][RW-1:0]    sin_o
);

  localparam int LUT_AW   = $clog2(4 * KMAX);
  localparam int LUT_N    = 1 << LUT_AW;
  localparam int FB       = 11;
  localparam int STEP_NUM = (LUT_N / 8) << FB;
  localparam int SW       = $clog2(STEP_NUM + 1);
  localparam int PHW      = LUT_AW + 1;
  localparam int PRW      = PHW + SW;
  localparam int AMP      = (1 << (RW - 1)) - 1;

  logic [KW-1:0]     k_eff;
  logic [LUT_AW-1:0] last;
  logic [SW-1:0]     step;
  logic [LUT_AW-1:0] n_q, n_d;
  logic [RW-1:0]     lut [LUT_N];

  // Effective K: zero reads as one, above range reads as the maximum
  always_comb begin
    if (k_sel == '0)               k_eff = KW'(1);
    else if (k_sel > KW'(KMAX))    k_eff = KW'(KMAX);
    else                           k_eff = k_sel;
    last = LUT_AW'(4 * int'(k_eff) - 1);
    step = SW'(STEP_NUM / int'(k_eff));
  end

  // Shared sample index, next state
  always_comb begin
    n_d = n_q;
    if (adv) n_d = (n_q >= last) ? '0 : n_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   n_q <= '0;
    else if (adv) n_q <= n_d;
  end

  for (genvar gi = 0; gi < LUT_N; gi++) begin : g_lut
    assign lut[gi] = RW'(tlx_pkg::cos_entry(gi, LUT_N / 2, AMP));
  end

  for (genvar gc = 0; gc < 2; gc++) begin : g_ch
    logic [PHW-1:0]             phase;
    logic [PRW-1:0]             prod;
    logic [LUT_AW-1:0]          addr;
    logic [KMAX-1:0][RW-1:0]    dl_q, dl_d;

    always_comb begin
      phase = {n_q, 1'b0} | PHW'(gc);
      prod  = PRW'(phase) * PRW'(step);
      addr  = LUT_AW'(prod >> FB);
    end

    assign cos_o[gc] = lut[addr];

    // Quarter-period delay line: sine is cosine from K samples ago
    always_comb begin
      dl_d = dl_q;
      if (adv) dl_d = {dl_q[KMAX-2:0], cos_o[gc]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dl_q <= '0;
      else if (adv) dl_q <= dl_d;
    end

    assign sin_o[gc] = dl_q[k_eff - 1'b1];

    // R3: a valid sample places the current cosine at the head of the delay line
    p_delay_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> dl_q[0] == $past(cos_o[gc]));
  end

  // R4: index never leaves the table period of the largest K
  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    n_q <= LUT_AW'(4 * KMAX - 1));

  // R9: no valid sample, no index movement
  p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(n_q));

endmodule

// File: rtl/tlx_lms_chan.sv
module tlx_lms_chan #(
  parameter int DW     = 14,
  parameter int RW     = 12,
  parameter int WW     = 22,
  parameter int WF     = 8,
  parameter int MUW    = 5,
  parameter int MU_MIN = 8,
  parameter int MU_MAX = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic [DW-1:0]  x_in,
  input  logic [RW-1:0]  cref,
  input  logic [RW-1:0]  sref,
  input  logic [MUW-1:0] mu_sh,
  output logic [DW-1:0]  clean_o,
  output logic [DW-1:0]  tone_o
);

  localparam int SH   = RW - 1 + WF;
  localparam int AW   = WW + RW + 1;
  localparam int YW   = AW - SH;
  localparam int EW   = YW + 1;
  localparam int PE   = EW + RW;
  localparam int OMAX = (1 << (DW - 1)) - 1;
  localparam int OMIN = -(1 << (DW - 1));
  localparam int WMAX = (1 << (WW - 1)) - 1;
  localparam int WMIN = -(1 << (WW - 1));

  logic signed [RW-1:0] c_s, s_s;
  logic signed [DW-1:0] x_s;
  logic signed [AW-1:0] acc;
  logic signed [YW-1:0] y_v;
  logic signed [EW-1:0] e_v;
  logic signed [PE-1:0] pc, ps;
  logic signed [WW+1:0] sum_c, sum_s;
  logic signed [WW-1:0] wc_q, wc_d, ws_q, ws_d;
  logic [DW-1:0]        clean_d, tone_d;

  function automatic logic signed [WW-1:0] wsat(input logic signed [WW+1:0] v);
    if (v > (WW+2)'(WMAX))      return WW'(WMAX);
    else if (v < (WW+2)'(WMIN)) return WW'(WMIN);
    else                        return WW'(v);
  endfunction

  assign c_s = signed'(cref);
  assign s_s = signed'(sref);
  assign x_s = signed'(x_in);

  // Tone estimate and residual
  always_comb begin
    acc = AW'(wc_q) * AW'(c_s) + AW'(ws_q) * AW'(s_s);
    y_v = YW'(acc >>> SH);
    e_v = EW'(x_s) - EW'(y_v);
  end

  // Weight update with shift step and saturation
  always_comb begin
    pc    = PE'(e_v) * PE'(c_s);
    ps    = PE'(e_v) * PE'(s_s);
    sum_c = (WW+2)'(wc_q) + (WW+2)'(pc >>> mu_sh);
    sum_s = (WW+2)'(ws_q) + (WW+2)'(ps >>> mu_sh);
    wc_d  = adv ? wsat(sum_c) : wc_q;
    ws_d  = adv ? wsat(sum_s) : ws_q;
  end

  // Output saturation
  always_comb begin
    clean_d = clean_o;
    tone_d  = tone_o;
    if (adv) begin
      if (e_v > EW'(OMAX))      clean_d = DW'(OMAX);
      else if (e_v < EW'(OMIN)) clean_d = DW'(OMIN);
      else                      clean_d = DW'(e_v);
      if (y_v > YW'(OMAX))      tone_d  = DW'(OMAX);
      else if (y_v < YW'(OMIN)) tone_d  = DW'(OMIN);
      else                      tone_d  = DW'(y_v);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_q    <= '0;
      ws_q    <= '0;
      clean_o <= '0;
      tone_o  <= '0;
    end else if (adv) begin
      wc_q    <= wc_d;
      ws_q    <= ws_d;
      clean_o <= clean_d;
      tone_o  <= tone_d;
    end
  end

  // Port-level split check: unsaturated outputs add back to the sample
  logic signed [DW:0] x_ext, split_sum;
  logic               any_sat;
  assign x_ext     = (DW+1)'(x_s);
  assign split_sum = (DW+1)'(signed'(clean_o)) + (DW+1)'(signed'(tone_o));
  assign any_sat   = (clean_o == DW'(OMAX)) || (clean_o == DW'(OMIN)) ||
                     (tone_o == DW'(OMAX))  || (tone_o == DW'(OMIN));

  // R5: residual plus estimate rebuilds the input
  p_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (any_sat || split_sum == $past(x_ext)));

  // R6: step shift arrives already clamped
  p_mu_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (mu_sh >= MUW'(MU_MIN) && mu_sh <= MUW'(MU_MAX)));

  // R9: idle cycles leave weights and outputs untouched
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(wc_q) && $stable(ws_q) && $stable(clean_o) && $stable(tone_o)));

endmodule

// File: rtl/tone_lms_extractor.sv
module tone_lms_extractor #(
  parameter int DW     = 14,
  parameter int RW     = 12,
  parameter int WW     = 22,
  parameter int WF     = 8,
  parameter int KMAX   = 63,
  parameter int MUW    = 5,
  parameter int MU_MIN = 8,
  parameter int MU_MAX = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [DW-1:0]             x0_in,
  input  logic [DW-1:0]             x1_in,
  input  logic [$clog2(KMAX+1)-1:0] k_sel,
  input  logic [MUW-1:0]            mu_sel,
  output logic                      out_valid,
  output logic [DW-1:0]             clean0,
  output logic [DW-1:0]             clean1,
  output logic [DW-1:0]             tone0,
  output logic [DW-1:0]             tone1
);

  localparam int KW = $clog2(KMAX + 1);

  logic [1:0][RW-1:0] cos_r, sin_r;
  logic [1:0][DW-1:0] x_v, clean_v, tone_v;
  logic [MUW-1:0]     mu_eff;
  logic               ov_d;

  always_comb begin
    if (mu_sel < MUW'(MU_MIN))      mu_eff = MUW'(MU_MIN);
    else if (mu_sel > MUW'(MU_MAX)) mu_eff = MUW'(MU_MAX);
    else                            mu_eff = mu_sel;
  end

  assign x_v[0] = x0_in;
  assign x_v[1] = x1_in;

  tlx_ref_gen #(.RW(RW), .KMAX(KMAX), .KW(KW)) u_ref (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (in_valid),
    .k_sel (k_sel),
    .cos_o (cos_r),
    .sin_o (sin_r)
  );

  for (genvar gc = 0; gc < 2; gc++) begin : g_lms
    tlx_lms_chan #(
      .DW(DW), .RW(RW), .WW(WW), .WF(WF),
      .MUW(MUW), .MU_MIN(MU_MIN), .MU_MAX(MU_MAX)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (in_valid),
      .x_in    (x_v[gc]),
      .cref    (cos_r[gc]),
      .sref    (sin_r[gc]),
      .mu_sh   (mu_eff),
      .clean_o (clean_v[gc]),
      .tone_o  (tone_v[gc])
    );
  end

  assign clean0 = clean_v[0];
  assign clean1 = clean_v[1];
  assign tone0  = tone_v[0];
  assign tone1  = tone_v[1];

  assign ov_d = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= ov_d;
  end

  // R8: a valid sample raises the strobe one clock later
  p_strobe_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9: an idle cycle lowers the strobe one clock later
  p_strobe_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

endmodule

// File: tb/tone_lms_extractor_bench.sv
module tone_lms_extractor_bench;
  localparam int DW = 14;
  localparam int KW = 6;
  localparam int MUW = 5;
  localparam int KMAX = 63;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n;
  logic           in_valid;
  logic [DW-1:0]  x0_in, x1_in;
  logic [KW-1:0]  k_sel;
  logic [MUW-1:0] mu_sel;
  logic           out_valid;
  logic [DW-1:0]  clean0, clean1, tone0, tone1;

  tone_lms_extractor u_tone_lms_extractor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x0_in(x0_in), .x1_in(x1_in), .k_sel(k_sel), .mu_sel(mu_sel),
    .out_valid(out_valid), .clean0(clean0), .clean1(clean1),
    .tone0(tone0), .tone1(tone1)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string tag = "R1";

  longint wc[2], ws[2];
  int     n_m;
  int     hist[2][$];
  int     m_ov;
  int     m_clean[2], m_tone[2];
  int     cur_c[2], cur_s[2];

  function automatic int tab(int a);
    int b, p, q, mag;
    b = (a + 64) % 256;
    p = b % 128;
    q = p * (128 - p);
    mag = (2047 * 16 * q) / (81920 - 4 * q);
    return (b < 128) ? mag : -mag;
  endfunction

  function automatic int keff(int k);
    return (k == 0) ? 1 : k;
  endfunction

  function automatic longint clampl(longint v, longint lo, longint hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      wc[c] = 0; ws[c] = 0; m_clean[c] = 0; m_tone[c] = 0;
      hist[c].delete();
      for (int i = 0; i < KMAX; i++) hist[c].push_back(0);
    end
    n_m = 0;
    m_ov = 0;
  endtask

  task automatic refs();
    int k;
    k = keff(int'(k_sel));
    for (int c = 0; c < 2; c++) begin
      cur_c[c] = tab((((2 * n_m + c) * (65536 / k)) >> 11) % 256);
      cur_s[c] = hist[c][k - 1];
    end
  endtask

  task automatic model_step(bit v, int xa, int xb);
    int     k, mu, xs;
    longint y, e;
    if (!v) begin
      m_ov = 0;
      return;
    end
    refs();
    k = keff(int'(k_sel));
    mu = int'(clampl(longint'(mu_sel), 8, 20));
    for (int c = 0; c < 2; c++) begin
      xs = (c == 0) ? xa : xb;
      y = (wc[c] * cur_c[c] + ws[c] * cur_s[c]) >>> 19;
      e = xs - y;
      m_clean[c] = int'(clampl(e, -8192, 8191));
      m_tone[c]  = int'(clampl(y, -8192, 8191));
      wc[c] = clampl(wc[c] + ((e * cur_c[c]) >>> mu), -2097152, 2097151);
      ws[c] = clampl(ws[c] + ((e * cur_s[c]) >>> mu), -2097152, 2097151);
      hist[c].push_front(cur_c[c]);
      void'(hist[c].pop_back());
    end
    n_m = (n_m >= 4 * k - 1) ? 0 : n_m + 1;
    m_ov = 1;
  endtask

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(int'(out_valid) == m_ov, "out_valid", int'(out_valid), m_ov);
    chk(int'($signed(clean0)) == m_clean[0], "clean0", int'($signed(clean0)), m_clean[0]);
    chk(int'($signed(clean1)) == m_clean[1], "clean1", int'($signed(clean1)), m_clean[1]);
    chk(int'($signed(tone0)) == m_tone[0], "tone0", int'($signed(tone0)), m_tone[0]);
    chk(int'($signed(tone1)) == m_tone[1], "tone1", int'($signed(tone1)), m_tone[1]);
  endtask

  // One cycle: drive after a falling edge, compare at the next falling edge
  task automatic cycle(bit v, int xa, int xb);
    in_valid = v;
    x0_in = DW'(xa);
    x1_in = DW'(xb);
    model_step(v, xa, xb);
    @(negedge clk);
    compare_all();
  endtask

  // mode 0: small tone; mode 1: full-scale square
  task automatic run(int cnt, int mode, int gap_pct);
    int xa, xb;
    for (int j = 0; j < cnt; j++) begin
      refs();
      if (mode == 0) begin
        xa = (82 * cur_c[0]) / 2047;
        xb = (60 * cur_c[1] + 50 * cur_s[1]) / 2047;
      end else begin
        xa = (cur_c[0] >= 0) ? 8191 : -8192;
        xb = (cur_c[1] >= 0) ? 8191 : -8192;
      end
      if (gap_pct > 0 && $urandom_range(99, 0) < gap_pct) cycle(0, xa ^ 37, xb ^ 91);
      else cycle(1, xa, xb);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R1";
    compare_all();
    rst_n = 1'b1;
    cycle(0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int mx0, mx1;
    x0_in = '0; x1_in = '0; k_sel = 6'd16; mu_sel = 5'd8;
    @(negedge clk);
    do_reset();

    // R2 R3 R5 R6 R8: tone tracking, K = 16
    tag = "R2 R3 R5 R6 R8";
    run(2936, 0, 0);
    // R10: residual bound after convergence
    tag = "R10";
    mx0 = 0; mx1 = 0;
    for (int j = 0; j < 64; j++) begin
      run(1, 0, 0);
      if ($signed(clean0) > mx0) mx0 = $signed(clean0);
      if (-$signed(clean0) > mx0) mx0 = -$signed(clean0);
      if ($signed(clean1) > mx1) mx1 = $signed(clean1);
      if (-$signed(clean1) > mx1) mx1 = -$signed(clean1);
    end
    chk(mx0 <= 4, "clean0 residual", mx0, 4);
    chk(mx1 <= 4, "clean1 residual", mx1, 4);

    // R9: idle cycles interleaved
    tag = "R9";
    run(400, 0, 40);

    // R4 R6: K = 1 and step below range
    tag = "R4 R6 k1";
    k_sel = 6'd1; mu_sel = 5'd3;
    run(300, 0, 0);

    // R4 R6: K at maximum and step above range
    tag = "R4 R6 k63";
    k_sel = 6'd63; mu_sel = 5'd25;
    run(830, 0, 0);

    // R4: lower K while the index is large
    tag = "R4 shrink";
    k_sel = 6'd5; mu_sel = 5'd12;
    run(120, 0, 0);

    // R4: zero read as one
    tag = "R4 k0";
    k_sel = 6'd0;
    run(100, 0, 0);

    // R7: weight saturation under full-scale square input
    tag = "R7";
    k_sel = 6'd16; mu_sel = 5'd8;
    run(1500, 1, 0);

    // R1: reset in mid-run
    do_reset();
    tag = "R3 after reset";
    run(40, 0, 0);

    finish_run();
  end
endmodule